// File: doc/BRIEF.md
# Eight-Bit Function-Select ALU

This block is a purely combinational arithmetic unit. It takes two operands, A and B, and a 3-bit function select. It returns a result of the operand width, a carry-out and a signed-overflow flag. Every function goes through one adder: a chain of identical 1-bit full-adder slices with ripple carry. The select only decides which word enters the adder's second input and what the carry-in is. Operands are two's complement values. The default width is eight bits.

A build-time parameter picks where the select comes from. In the direct variant it is the `op_sel` port. In the decode variant it comes from a 16-bit instruction word. When the two mode bits [1:0] are 11, the select is bits [4:2]. For any other mode value the unit falls back to transfer. The unit holds no state: operand storage, clocking and write-back belong to the surrounding datapath.

Top module: `fsel_alu`

## Requirements
- R1: Select 000 and select 111 both return A unchanged, with carry-out 0 and overflow 0.
- R2: Select 001 returns A+1 (A plus a zero word with carry-in 1), so 0xFF wraps to 0x00 with carry-out 1.
- R3: Select 010 returns A+B, and select 011 returns A+B+1.
- R4: Select 100 returns A plus the bitwise inverse of B, with carry-in 0.
- R5: Select 101 returns A plus the inverse of B plus 1, which equals A-B modulo 2^width.
- R6: Select 110 returns A-1 (A plus an all-ones word with carry-in 0), so 0x00 gives 0xFF with carry-out 0.
- R7: carry_out is the carry leaving the most significant slice of the ripple chain.
- R8: ovf_flag is 1 exactly when the adder's two inputs have the same sign bit and the result's sign bit differs from it.
- R9: The outputs depend only on the present inputs. A change of operands or select shows at the outputs with no clock edge.
- R10: In the decode variant, instr_word[1:0] == 2'b11 selects the function instr_word[4:2]. Any other mode value selects transfer, and op_sel has no effect.
- R11: In the decode variant, instr_word[15:5] has no effect on any output.
- R12: In the direct variant, op_sel selects the function and instr_word has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | DATA_W (8) | First operand, two's complement |
| opnd_b | input | DATA_W (8) | Second operand, two's complement |
| op_sel | input | 3 | Function select, used in the direct variant |
| instr_word | input | INSTR_W (16) | Instruction word, decoded in the decode variant |
| result | output | DATA_W (8) | Adder sum for the selected function |
| carry_out | output | 1 | Carry out of the most significant slice |
| ovf_flag | output | 1 | Signed overflow of the addition |

## Verification
The bench builds three copies of the unit.

- **Direct, width 8.** Runs a literal vector table covering every select code, including the wrap points at 0x7F, 0x80, 0xFF and 0x00. It also checks that instr_word has no effect in this variant.
- **Decode, width 8.** Checks mode gating and the fallback to transfer when the mode is not 11. It confirms that rewriting the upper eleven instruction bits leaves the outputs unchanged.
- **Direct, width 4.** All eight selects over every operand pair fit in 2048 combinations. This sweeps every carry and overflow pattern of the slice chain against an independent signed-range model.

// File: rtl/fsel_alu_pkg.sv
package fsel_alu_pkg;

   typedef enum logic [2:0] {
      FN_PASS_LO  = 3'b000,
      FN_INC      = 3'b001,
      FN_ADD      = 3'b010,
      FN_ADD_ONE  = 3'b011,
      FN_ADD_INV  = 3'b100,
      FN_SUB      = 3'b101,
      FN_DEC      = 3'b110,
      FN_PASS_HI  = 3'b111
   } alu_fn_e;

   localparam int unsigned FN_W     = 3;
   localparam int unsigned MODE_W   = 2;
   localparam logic [1:0]  MODE_ALU = 2'b11;

   function automatic logic fn_is_pass(input alu_fn_e fn);
      return (fn == FN_PASS_LO) || (fn == FN_PASS_HI);
   endfunction

endpackage

// File: rtl/fsel_alu_slice.sv
module fsel_alu_slice (
   input  logic a_bit,
   input  logic b_bit,
   input  logic c_in,
   output logic s_bit,
   output logic c_out
);

   logic half_sum;
   logic gen_term;
   logic prop_term;

   always_comb begin
      half_sum  = a_bit ^ b_bit;
      gen_term  = a_bit & b_bit;
      prop_term = half_sum & c_in;
      s_bit     = half_sum ^ c_in;
      c_out     = gen_term | prop_term;
   end

endmodule

// File: rtl/fsel_alu_chain.sv
module fsel_alu_chain #(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] add_x,
   input  logic [WIDTH-1:0] add_y,
   input  logic             c_first,
   output logic [WIDTH-1:0] sum,
   output logic             c_last
);

   localparam int unsigned CW = WIDTH + 1;

   logic [CW-1:0] carry;

   assign carry[0] = c_first;

   for (genvar i = 0; i < WIDTH; i++) begin : g_slice
      fsel_alu_slice u_slice (
         .a_bit (add_x[i]),
         .b_bit (add_y[i]),
         .c_in  (carry[i]),
         .s_bit (sum[i]),
         .c_out (carry[i+1])
      );
   end

   assign c_last = carry[WIDTH];

   // R7: the slice chain must agree with a wide arithmetic sum
   always_comb begin
      p_chain_sum_r7: assert ({c_last, sum} ==
                              ({1'b0, add_x} + {1'b0, add_y} + {{WIDTH{1'b0}}, c_first}))
         else $error("ripple chain disagrees with arithmetic sum");
   end

endmodule

// File: rtl/fsel_alu_prep.sv
module fsel_alu_prep
   import fsel_alu_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  alu_fn_e          fn,
   input  logic [WIDTH-1:0] opnd_b,
   output logic [WIDTH-1:0] y_word,
   output logic             c_seed
);

   localparam logic [WIDTH-1:0] ZERO_W = '0;
   localparam logic [WIDTH-1:0] ONES_W = '1;

   always_comb begin
      y_word = ZERO_W;
      c_seed = 1'b0;
      unique case (fn)
         FN_PASS_LO, FN_PASS_HI: begin y_word = ZERO_W;  c_seed = 1'b0; end
         FN_INC:                 begin y_word = ZERO_W;  c_seed = 1'b1; end
         FN_ADD:                 begin y_word = opnd_b;  c_seed = 1'b0; end
         FN_ADD_ONE:             begin y_word = opnd_b;  c_seed = 1'b1; end
         FN_ADD_INV:             begin y_word = ~opnd_b; c_seed = 1'b0; end
         FN_SUB:                 begin y_word = ~opnd_b; c_seed = 1'b1; end
         FN_DEC:                 begin y_word = ONES_W;  c_seed = 1'b0; end
         default:                begin y_word = ZERO_W;  c_seed = 1'b0; end
      endcase
   end

   // R1: a pass function must feed nothing into the adder
   always_comb begin
      if (fn_is_pass(fn)) begin
         p_pass_quiet_r1: assert (y_word == ZERO_W && !c_seed)
            else $error("pass function drives a nonzero adder input");
      end
   end

endmodule

// File: rtl/fsel_alu_sel.sv
module fsel_alu_sel
   import fsel_alu_pkg::*;
#(
   parameter bit          DECODE  = 1'b0,
   parameter int unsigned INSTR_W = 16
) (
   input  logic [FN_W-1:0]    op_sel,
   input  logic [INSTR_W-1:0] instr_word,
   output alu_fn_e            fn
);

   if (DECODE) begin : g_decode
      logic [MODE_W-1:0] mode_bits;
      logic [FN_W-1:0]   fn_bits;
      logic              unused_sel;

      assign mode_bits  = instr_word[MODE_W-1:0];
      assign fn_bits    = instr_word[MODE_W+FN_W-1:MODE_W];
      assign unused_sel = ^{op_sel, instr_word[INSTR_W-1:MODE_W+FN_W]};

      always_comb begin
         if (mode_bits == MODE_ALU) fn = alu_fn_e'(fn_bits);
         else                       fn = FN_PASS_LO;
      end

      // R10: anything but the ALU mode falls back to a pass
      always_comb begin
         if (instr_word[1:0] != 2'b11) begin
            p_mode_fallback_r10: assert (fn_is_pass(fn))
               else $error("non-ALU mode did not fall back to pass");
         end
      end
   end else begin : g_direct
      logic unused_instr;

      assign unused_instr = ^instr_word;
      assign fn           = alu_fn_e'(op_sel);
   end

endmodule

// File: rtl/fsel_alu.sv
module fsel_alu
   import fsel_alu_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned INSTR_W = 16,
   parameter bit          DECODE  = 1'b0
) (
   input  logic [DATA_W-1:0]  opnd_a,
   input  logic [DATA_W-1:0]  opnd_b,
   input  logic [2:0]         op_sel,
   input  logic [INSTR_W-1:0] instr_word,
   output logic [DATA_W-1:0]  result,
   output logic               carry_out,
   output logic               ovf_flag
);

   localparam int unsigned MSB  = DATA_W - 1;
   localparam int unsigned EXTW = DATA_W + 1;

   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end
   if (INSTR_W < MODE_W + FN_W) begin : g_bad_instr
      $error("INSTR_W must hold the mode and function fields");
   end

   alu_fn_e           fn;
   logic [DATA_W-1:0] y_word;
   logic              c_seed;
   logic [DATA_W-1:0] sum;
   logic              c_last;

   fsel_alu_sel #(
      .DECODE  (DECODE),
      .INSTR_W (INSTR_W)
   ) u_sel (
      .op_sel     (op_sel),
      .instr_word (instr_word),
      .fn         (fn)
   );

   fsel_alu_prep #(
      .WIDTH (DATA_W)
   ) u_prep (
      .fn     (fn),
      .opnd_b (opnd_b),
      .y_word (y_word),
      .c_seed (c_seed)
   );

   fsel_alu_chain #(
      .WIDTH (DATA_W)
   ) u_chain (
      .add_x   (opnd_a),
      .add_y   (y_word),
      .c_first (c_seed),
      .sum     (sum),
      .c_last  (c_last)
   );

   always_comb begin
      result    = sum;
      carry_out = c_last;
      ovf_flag  = (opnd_a[MSB] == y_word[MSB]) && (sum[MSB] != opnd_a[MSB]);
   end

   // Function checks against plain arithmetic on the ports
   logic signed [EXTW-1:0] wide_sum;
   always_comb begin
      wide_sum = $signed({opnd_a[MSB], opnd_a}) + $signed({y_word[MSB], y_word})
               + $signed({{DATA_W{1'b0}}, c_seed});
      p_ovf_range_r8: assert (ovf_flag == (wide_sum[EXTW-1] != wide_sum[EXTW-2]))
         else $error("overflow flag disagrees with signed range");
      if (fn_is_pass(fn)) begin
         p_no_overflow_r1: assert (result == opnd_a && !carry_out && !ovf_flag)
            else $error("pass function altered operand");
      end
      if (fn == FN_INC) begin
         p_inc_r2: assert (result == opnd_a + DATA_W'(1))
            else $error("increment wrong");
      end
      if (fn == FN_ADD) begin
         p_add_r3: assert (result == opnd_a + opnd_b)
            else $error("add wrong");
      end
      if (fn == FN_ADD_INV) begin
         p_add_inv_r4: assert (result == opnd_a + ~opnd_b)
            else $error("add inverse wrong");
      end
      if (fn == FN_SUB) begin
         p_sub_r5: assert (result == opnd_a - opnd_b)
            else $error("subtract wrong");
      end
      if (fn == FN_DEC) begin
         p_dec_r6: assert (result == opnd_a - DATA_W'(1))
            else $error("decrement wrong");
      end
   end

endmodule

// File: tb/tb_fsel_alu.sv
module tb_fsel_alu;

   localparam time HALF = 10ns;   // 50 MHz
   localparam int  NVEC = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #HALF clk = ~clk;

   int n_chk  = 0;
   int n_fail = 0;
   int cycles = 0;

   logic [7:0]  a8, b8;
   logic [2:0]  sel_d, sel_x;
   logic [15:0] iw_d, iw_x;
   logic [7:0]  r_d, r_x;
   logic        co_d, co_x, ov_d, ov_x;

   logic [3:0]  a4, b4, r4;
   logic [2:0]  sel4;
   logic        co4, ov4;

   fsel_alu #(.DATA_W(8), .INSTR_W(16), .DECODE(1'b0)) dut (
      .opnd_a(a8), .opnd_b(b8), .op_sel(sel_d), .instr_word(iw_d),
      .result(r_d), .carry_out(co_d), .ovf_flag(ov_d));

   fsel_alu #(.DATA_W(8), .INSTR_W(16), .DECODE(1'b1)) dut_dec (
      .opnd_a(a8), .opnd_b(b8), .op_sel(sel_x), .instr_word(iw_x),
      .result(r_x), .carry_out(co_x), .ovf_flag(ov_x));

   fsel_alu #(.DATA_W(4), .INSTR_W(16), .DECODE(1'b0)) dut_w4 (
      .opnd_a(a4), .opnd_b(b4), .op_sel(sel4), .instr_word(16'h0000),
      .result(r4), .carry_out(co4), .ovf_flag(ov4));

   // {sel, a, b, result, carry, overflow}
   localparam logic [28:0] VEC [NVEC] = '{
      {3'b000, 8'h5A, 8'h33, 8'h5A, 1'b0, 1'b0},  // R1
      {3'b111, 8'h80, 8'hFF, 8'h80, 1'b0, 1'b0},  // R1
      {3'b001, 8'h7F, 8'h00, 8'h80, 1'b0, 1'b1},  // R2 R8
      {3'b001, 8'hFF, 8'h12, 8'h00, 1'b1, 1'b0},  // R2 R7
      {3'b010, 8'h10, 8'h22, 8'h32, 1'b0, 1'b0},  // R3
      {3'b010, 8'h70, 8'h20, 8'h90, 1'b0, 1'b1},  // R3 R8
      {3'b010, 8'hF0, 8'h20, 8'h10, 1'b1, 1'b0},  // R3 R7
      {3'b011, 8'h10, 8'h22, 8'h33, 1'b0, 1'b0},  // R3
      {3'b011, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b0},  // R3 R7
      {3'b100, 8'h10, 8'h03, 8'h0C, 1'b1, 1'b0},  // R4
      {3'b100, 8'h7F, 8'h80, 8'hFE, 1'b0, 1'b1},  // R4 R8
      {3'b101, 8'h10, 8'h03, 8'h0D, 1'b1, 1'b0},  // R5
      {3'b101, 8'h03, 8'h10, 8'hF3, 1'b0, 1'b0},  // R5
      {3'b101, 8'h80, 8'h01, 8'h7F, 1'b1, 1'b1},  // R5 R8
      {3'b110, 8'h00, 8'h55, 8'hFF, 1'b0, 1'b0},  // R6
      {3'b110, 8'h80, 8'h00, 8'h7F, 1'b1, 1'b1}   // R6 R8
   };

   task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual res=%h co=%b ov=%b expected res=%h co=%b ov=%b",
                  tag, act[9:2], act[1], act[0], exp[9:2], exp[1], exp[0]);
      end
   endtask

   task automatic settle();
      @(posedge clk);
      #(HALF / 2);
   endtask

   // Independent width-4 model built from the requirement text
   function automatic logic [5:0] model4(input logic [2:0] s, input logic [3:0] a,
                                         input logic [3:0] b);
      int ua, ub, cin, us, sa, sb, ss;
      ua = int'(a); sa = (ua > 7) ? ua - 16 : ua;
      case (s)
         3'b001:  begin ub = 0;          cin = 1; end
         3'b010:  begin ub = int'(b);    cin = 0; end
         3'b011:  begin ub = int'(b);    cin = 1; end
         3'b100:  begin ub = 15 - int'(b); cin = 0; end
         3'b101:  begin ub = 15 - int'(b); cin = 1; end
         3'b110:  begin ub = 15;         cin = 0; end
         default: begin ub = 0;          cin = 0; end
      endcase
      sb = (ub > 7) ? ub - 16 : ub;
      us = ua + ub + cin;
      ss = sa + sb + cin;
      return {4'(us), (us > 15), (ss > 7 || ss < -8)};
   endfunction

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual cycles=%0d expected completion", cycles);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      a8 = '0; b8 = '0; sel_d = '0; sel_x = '0; iw_d = '0; iw_x = '0;
      a4 = '0; b4 = '0; sel4 = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // Idle state: zero operands, pass select
      settle();
      check("R1 idle zero", {r_d, co_d, ov_d}, 10'b0);

      // Vector table, direct variant
      foreach (VEC[i]) begin
         sel_d = VEC[i][28:26];
         a8    = VEC[i][25:18];
         b8    = VEC[i][17:10];
         iw_d  = 16'h0000;
         settle();
         check($sformatf("R%0s vec %0d", "1-8", i), {r_d, co_d, ov_d}, VEC[i][9:0]);
      end

      // R9: inputs change mid-cycle, output follows before the next edge
      sel_d = 3'b010; a8 = 8'h01; b8 = 8'h01;
      @(posedge clk); #2;
      a8 = 8'h40; #3;
      check("R9 follows input without edge", {r_d, co_d, ov_d}, {8'h41, 2'b00});

      // R12: instr_word has no effect in the direct variant
      sel_d = 3'b101; a8 = 8'h20; b8 = 8'h05; iw_d = 16'hFFFF;
      settle();
      check("R12 instr ignored (direct)", {r_d, co_d, ov_d}, {8'h1B, 2'b10});
      iw_d = 16'h5A3C;
      settle();
      check("R12 instr ignored again", {r_d, co_d, ov_d}, {8'h1B, 2'b10});

      // R10: decode variant, ALU mode selects [4:2]
      a8 = 8'h10; b8 = 8'h22;
      iw_x = {11'h000, 3'b010, 2'b11}; sel_x = 3'b000;
      settle();
      check("R10 decoded add", {r_x, co_x, ov_x}, {8'h32, 2'b00});
      iw_x = 16'hFFFF;  // select 111 in ALU mode
      settle();
      check("R10 decoded pass 111", {r_x, co_x, ov_x}, {8'h10, 2'b00});
      iw_x = {11'h000, 3'b010, 2'b01}; sel_x = 3'b010;
      settle();
      check("R10 mode 01 falls back to pass", {r_x, co_x, ov_x}, {8'h10, 2'b00});
      iw_x = {11'h000, 3'b101, 2'b10}; sel_x = 3'b101;
      settle();
      check("R10 mode 10 falls back to pass", {r_x, co_x, ov_x}, {8'h10, 2'b00});
      iw_x = {11'h000, 3'b101, 2'b11}; sel_x = 3'b011;
      settle();
      check("R10 op_sel ignored, decoded sub", {r_x, co_x, ov_x}, {8'hEE, 2'b00});

      // R11: upper instruction bits have no effect
      iw_x = {11'h7FF, 3'b101, 2'b11};
      settle();
      check("R11 upper bits all ones", {r_x, co_x, ov_x}, {8'hEE, 2'b00});
      iw_x = {11'h2A5, 3'b101, 2'b11};
      settle();
      check("R11 upper bits pattern", {r_x, co_x, ov_x}, {8'hEE, 2'b00});

      // Exhaustive width-4 sweep: R1..R8 on every carry pattern
      for (int s = 0; s < 8; s++) begin
         for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
               sel4 = 3'(s); a4 = 4'(x); b4 = 4'(y);
               #(HALF / 4);
               n_chk++;
               if ({r4, co4, ov4} !== model4(3'(s), 4'(x), 4'(y))) begin
                  n_fail++;
                  $display("FAIL R7 R8 w4 sel=%0d a=%h b=%h: actual %b expected %b",
                           s, x, y, {r4, co4, ov4}, model4(3'(s), 4'(x), 4'(y)));
               end
            end
         end
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule